// File: doc/BRIEF.md
# Banked Data Memory Address Decoder

This block sits between an 8-bit core's operand path and its data storage. Every access carries either a direct address, built from a 5-bit bank number and a 7-bit offset taken from the instruction, or a 16-bit indirect pointer. The block turns the access into a 12-bit linear data address and sorts it into one of five regions. The regions are core registers, peripheral registers, general purpose RAM, shared common RAM, and unimplemented space.

Core-register and peripheral-register accesses go out on a register bus with two separate select strobes. General purpose RAM and common RAM sit in an internal RAM that infers as block RAM. A pointer with bit 15 set aims at program memory. Such a read stalls for one extra cycle and then completes with the program-memory flag raised. Fetching the program word is left to the surrounding logic. Read results appear one clock after the request is accepted, except for program-memory reads.

Top module: `bank_dmem_decoder`

## Requirements
- R1: After a synchronous active-high reset, `rd_valid`, `stall` and `pm_hit` are low.
- R2: A direct access uses the linear address {bank[4:0], offset[6:0]}. An accepted read asserts `rd_valid` with its data in the following cycle, and a write never asserts `rd_valid`.
- R3: Offsets 0x00 to 0x0B select core registers in every bank. `core_sel` is raised in the request cycle with `reg_addr` equal to the linear address, and `reg_rdata` sampled then becomes `rd_data`.
- R4: Offsets 0x0C to 0x1F raise `sfr_sel` instead of `core_sel`, with the full bank-specific address on `reg_addr`.
- R5: Offsets 0x20 to 0x6F in banks below GPR_BANKS (default 3) are distinct RAM bytes for each bank.
- R6: Offsets 0x70 to 0x7F reach the same 16 bytes of common RAM from any bank.
- R7: General purpose offsets in banks at or above GPR_BANKS are unimplemented. Reads of them return 0, writes to them change nothing, and no strobe is raised.
- R8: An indirect access with pointer bit 15 clear uses pointer bits 11:0 as the linear address and ignores bits 14:12.
- R9: An indirect read with pointer bit 15 set raises no strobe and holds `stall` high for exactly one clock. In the next cycle it gives `rd_valid` and `pm_hit` high with `rd_data` 0.
- R10: A write through a pointer with bit 15 set is discarded. It raises no strobe, no `stall` and no `rd_valid`, and it changes no RAM byte.
- R11: A request presented while `stall` is high is ignored. It raises no strobe and causes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_indirect | input | 1 | 1 = use req_ptr, 0 = use bank and offset |
| req_bank | input | 5 | Bank number for direct access |
| req_offset | input | 7 | Offset within the bank for direct access |
| req_ptr | input | 16 | Indirect pointer; bit 15 selects program memory |
| req_wdata | input | 8 | Write data |
| core_sel | output | 1 | Core-register select strobe |
| sfr_sel | output | 1 | Peripheral-register select strobe |
| reg_we | output | 1 | Register bus write enable |
| reg_addr | output | 12 | Register bus linear address |
| reg_wdata | output | 8 | Register bus write data |
| reg_rdata | input | 8 | Register bus read data, same cycle as the strobe |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result |
| pm_hit | output | 1 | Read result came from a program-memory pointer |
| stall | output | 1 | Extra cycle of a program-memory read |

## Verification
Most wrong decoding shows up in the same cycle as the request, as the wrong strobe or a wrong `reg_addr`. A wrong RAM index does not show up until the location is read back. It appears either as a bank that sees another bank's byte, or as common RAM that differs between banks. Unimplemented space that aliases into RAM only shows as a later read of the aliased byte. So every write is paired with reads from other banks and from neighbouring regions. A broken stall sequence shows within two cycles as a missing or extra `rd_valid`, `pm_hit` or `stall`.

// File: rtl/bank_dmem_pkg.sv
package bank_dmem_pkg;

  localparam int BANK_W = 5;
  localparam int OFS_W  = 7;
  localparam int ADDR_W = BANK_W + OFS_W;

  // Region boundaries within a bank (behavioural, fixed)
  localparam int CORE_LAST = 'h0B;
  localparam int SFR_LAST  = 'h1F;
  localparam int GPR_FIRST = 'h20;
  localparam int GPR_LAST  = 'h6F;
  localparam int GPR_SPAN  = GPR_LAST - GPR_FIRST + 1;
  localparam int SHARED_N  = 16;

  typedef enum logic [2:0] {
    RG_CORE   = 3'd0,
    RG_SFR    = 3'd1,
    RG_GPR    = 3'd2,
    RG_SHARED = 3'd3,
    RG_NONE   = 3'd4,
    RG_PROG   = 3'd5
  } region_e;

endpackage

// File: rtl/bank_addr_gen.sv
module bank_addr_gen #(
  parameter int BANK_W = 5,
  parameter int OFS_W  = 7,
  parameter int PTR_W  = 16,
  localparam int ADDR_W = BANK_W + OFS_W
) (
  input  logic              indirect,
  input  logic [BANK_W-1:0] bank,
  input  logic [OFS_W-1:0]  offset,
  input  logic [PTR_W-1:0]  ptr,
  output logic [ADDR_W-1:0] lin_addr,
  output logic              to_prog
);
  logic addr_unused;
  assign addr_unused = ^ptr[PTR_W-2:ADDR_W];

  always_comb begin
    if (indirect) lin_addr = ptr[ADDR_W-1:0];
    else          lin_addr = {bank, offset};
    to_prog = indirect & ptr[PTR_W-1];
  end
endmodule

// File: rtl/bank_region_dec.sv
module bank_region_dec
  import bank_dmem_pkg::*;
#(
  parameter int BANK_W    = 5,
  parameter int OFS_W     = 7,
  parameter int GPR_BANKS = 3,
  parameter int RAM_AW    = 8,
  localparam int ADDR_W   = BANK_W + OFS_W
) (
  input  logic [ADDR_W-1:0] lin_addr,
  input  logic              to_prog,
  output region_e           region,
  output logic [RAM_AW-1:0] ram_idx
);
  logic [BANK_W-1:0] bank;
  logic [OFS_W-1:0]  ofs;
  int unsigned       idx;

  assign bank = lin_addr[ADDR_W-1:OFS_W];
  assign ofs  = lin_addr[OFS_W-1:0];

  always_comb begin
    idx = 0;
    if (to_prog) begin
      region = RG_PROG;
    end else if (int'(ofs) <= CORE_LAST) begin
      region = RG_CORE;
    end else if (int'(ofs) <= SFR_LAST) begin
      region = RG_SFR;
    end else if (int'(ofs) <= GPR_LAST) begin
      if (int'(bank) < GPR_BANKS) begin
        region = RG_GPR;
        idx = int'(bank) * GPR_SPAN + (int'(ofs) - GPR_FIRST);
      end else begin
        region = RG_NONE;
      end
    end else begin
      region = RG_SHARED;
      idx = GPR_BANKS * GPR_SPAN + int'(ofs[3:0]);
    end
    ram_idx = idx[RAM_AW-1:0];
  end
endmodule

// File: rtl/bank_dmem_ram.sv
module bank_dmem_ram #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/bank_dmem_decoder.sv
module bank_dmem_decoder
  import bank_dmem_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PTR_W     = 16,
  parameter int GPR_BANKS = 3,
  localparam int RAM_DEPTH = GPR_BANKS * GPR_SPAN + SHARED_N,
  localparam int RAM_AW    = $clog2(RAM_DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic                  req_indirect,
  input  logic [BANK_W-1:0]     req_bank,
  input  logic [OFS_W-1:0]      req_offset,
  input  logic [PTR_W-1:0]      req_ptr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  core_sel,
  output logic                  sfr_sel,
  output logic                  reg_we,
  output logic [ADDR_W-1:0]     reg_addr,
  output logic [DATA_W-1:0]     reg_wdata,
  input  logic [DATA_W-1:0]     reg_rdata,
  output logic                  rd_valid,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  pm_hit,
  output logic                  stall
);
  logic [ADDR_W-1:0] lin_addr;
  logic              to_prog;
  region_e           region;
  logic [RAM_AW-1:0] ram_idx;
  logic              accept, is_ram, ram_we, ram_re;
  logic [DATA_W-1:0] ram_q;

  logic              stall_q, valid_q, pm_q;
  region_e           src_q;
  logic [DATA_W-1:0] ext_q;

  bank_addr_gen #(.BANK_W(BANK_W), .OFS_W(OFS_W), .PTR_W(PTR_W)) u_agen (
    .indirect (req_indirect),
    .bank     (req_bank),
    .offset   (req_offset),
    .ptr      (req_ptr),
    .lin_addr (lin_addr),
    .to_prog  (to_prog)
  );

  bank_region_dec #(.BANK_W(BANK_W), .OFS_W(OFS_W), .GPR_BANKS(GPR_BANKS),
                    .RAM_AW(RAM_AW)) u_dec (
    .lin_addr (lin_addr),
    .to_prog  (to_prog),
    .region   (region),
    .ram_idx  (ram_idx)
  );

  assign accept = req_valid & ~stall_q;
  assign is_ram = (region == RG_GPR) | (region == RG_SHARED);
  assign ram_we = accept & req_write & is_ram;
  assign ram_re = accept & ~req_write & is_ram;

  bank_dmem_ram #(.DEPTH(RAM_DEPTH), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .re    (ram_re),
    .addr  (ram_idx),
    .wdata (req_wdata),
    .q     (ram_q)
  );

  // Register bus strobes, issued in the request cycle
  assign core_sel  = accept & (region == RG_CORE);
  assign sfr_sel   = accept & (region == RG_SFR);
  assign reg_we    = (core_sel | sfr_sel) & req_write;
  assign reg_addr  = lin_addr;
  assign reg_wdata = req_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_q <= 1'b0;
      valid_q <= 1'b0;
      pm_q    <= 1'b0;
      src_q   <= RG_NONE;
      ext_q   <= '0;
    end else begin
      stall_q <= accept & ~req_write & to_prog;
      valid_q <= (accept & ~req_write & ~to_prog) | stall_q;
      pm_q    <= stall_q;
      if (accept & ~req_write) begin
        src_q <= region;
        ext_q <= reg_rdata;
      end
    end
  end

  always_comb begin
    unique case (src_q)
      RG_GPR, RG_SHARED: rd_data = ram_q;
      RG_CORE, RG_SFR:   rd_data = ext_q;
      default:           rd_data = '0;
    endcase
  end

  assign rd_valid = valid_q;
  assign pm_hit   = pm_q;
  assign stall    = stall_q;
endmodule

// File: rtl/bank_dmem_checker.sv
module bank_dmem_checker #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_indirect,
  input logic [PTR_W-1:0]  req_ptr,
  input logic              core_sel,
  input logic              sfr_sel,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              pm_hit,
  input logic              stall
);
  logic pm_req;
  assign pm_req = req_valid & req_indirect & req_ptr[PTR_W-1];

  assert_strobe_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({core_sel, sfr_sel}));

  assert_core_range_R3: assert property (@(posedge clk) disable iff (rst)
    core_sel |-> (reg_addr[6:0] <= 7'h0B));

  assert_read_next_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !stall && !req_write && !pm_req) |=> (rd_valid && !pm_hit));

  assert_write_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !stall && req_write) |=> !rd_valid);

  assert_pm_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (pm_req && !stall && !req_write) |=> stall);

  assert_stall_once_R9: assert property (@(posedge clk) disable iff (rst)
    stall |=> (!stall && rd_valid && pm_hit && rd_data == '0));

  assert_pm_no_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    pm_req |-> (!core_sel && !sfr_sel));

  assert_stall_ignore_R11: assert property (@(posedge clk) disable iff (rst)
    stall |-> (!core_sel && !sfr_sel));
endmodule

bind bank_dmem_decoder bank_dmem_checker #(
  .DATA_W(DATA_W), .PTR_W(PTR_W), .ADDR_W(bank_dmem_pkg::ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_indirect(req_indirect), .req_ptr(req_ptr), .core_sel(core_sel),
  .sfr_sel(sfr_sel), .reg_addr(reg_addr), .rd_valid(rd_valid),
  .rd_data(rd_data), .pm_hit(pm_hit), .stall(stall)
);

// File: tb/tb_bank_dmem_decoder.sv
module tb_bank_dmem_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_indirect = 1'b0;
  logic [4:0]  req_bank = '0;
  logic [6:0]  req_offset = '0;
  logic [15:0] req_ptr = '0;
  logic [7:0]  req_wdata = '0;
  logic        core_sel, sfr_sel, reg_we;
  logic [11:0] reg_addr;
  logic [7:0]  reg_wdata, reg_rdata, rd_data;
  logic        rd_valid, pm_hit, stall;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Register bus model: core regs return addr^3C, peripheral regs addr^A5
  assign reg_rdata = core_sel ? (reg_addr[7:0] ^ 8'h3C) :
                     sfr_sel  ? (reg_addr[7:0] ^ 8'hA5) : 8'h00;

  bank_dmem_decoder dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_indirect(req_indirect), .req_bank(req_bank), .req_offset(req_offset),
    .req_ptr(req_ptr), .req_wdata(req_wdata), .core_sel(core_sel),
    .sfr_sel(sfr_sel), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .pm_hit(pm_hit), .stall(stall)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive_dir(input bit w, input logic [4:0] b, input logic [6:0] o,
                           input logic [7:0] d);
    req_valid = 1'b1; req_write = w; req_indirect = 1'b0;
    req_bank = b; req_offset = o; req_wdata = d;
  endtask

  task automatic drive_ind(input bit w, input logic [15:0] p, input logic [7:0] d);
    req_valid = 1'b1; req_write = w; req_indirect = 1'b1;
    req_ptr = p; req_wdata = d;
  endtask

  task automatic idle();
    req_valid = 1'b0; req_write = 1'b0; req_indirect = 1'b0;
  endtask

  task automatic wr_dir(input logic [4:0] b, input logic [6:0] o, input logic [7:0] d);
    drive_dir(1'b1, b, o, d);
    step();
    idle();
  endtask

  task automatic rd_dir_chk(input logic [4:0] b, input logic [6:0] o,
                            input logic [7:0] exp, input string req);
    drive_dir(1'b0, b, o, 8'h00);
    step();
    idle();
    check(rd_valid === 1'b1 && pm_hit === 1'b0, req, {rd_valid, pm_hit}, 2'b10);
    check(rd_data === exp, req, rd_data, exp);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    check(rd_valid === 1'b0 && stall === 1'b0 && pm_hit === 1'b0, "R1",
          {rd_valid, stall, pm_hit}, 0);
  endtask

  task automatic t_gpr_banks();
    wr_dir(5'd0, 7'h25, 8'h11);
    wr_dir(5'd1, 7'h25, 8'h22);
    drive_dir(1'b1, 5'd2, 7'h25, 8'h33);
    step();
    idle();
    check(rd_valid === 1'b0, "R2 write gives no rd_valid", rd_valid, 0);
    rd_dir_chk(5'd0, 7'h25, 8'h11, "R5 bank0");
    rd_dir_chk(5'd1, 7'h25, 8'h22, "R5 bank1");
    rd_dir_chk(5'd2, 7'h25, 8'h33, "R5 bank2");
    wr_dir(5'd1, 7'h6F, 8'h4D);
    rd_dir_chk(5'd1, 7'h6F, 8'h4D, "R2 last gpr offset");
  endtask

  task automatic t_core();
    drive_dir(1'b0, 5'd7, 7'h03, 8'h00);
    #1;
    check(core_sel === 1'b1 && sfr_sel === 1'b0, "R3 strobe", {core_sel, sfr_sel}, 2'b10);
    check(reg_addr === 12'h383, "R3 addr", reg_addr, 12'h383);
    step();
    idle();
    check(rd_valid === 1'b1 && rd_data === (8'h83 ^ 8'h3C), "R3 data", rd_data, 8'h83 ^ 8'h3C);
    drive_dir(1'b1, 5'd0, 7'h0B, 8'h6E);
    #1;
    check(core_sel === 1'b1 && reg_we === 1'b1 && reg_wdata === 8'h6E && reg_addr === 12'h00B,
          "R3 write at 0x0B", {core_sel, reg_we, reg_addr}, {2'b11, 12'h00B});
    step();
    idle();
  endtask

  task automatic t_sfr();
    drive_dir(1'b0, 5'd2, 7'h11, 8'h00);
    #1;
    check(sfr_sel === 1'b1 && core_sel === 1'b0 && reg_addr === 12'h111, "R4 strobe",
          {sfr_sel, core_sel, reg_addr}, {2'b10, 12'h111});
    step();
    idle();
    check(rd_valid === 1'b1 && rd_data === (8'h11 ^ 8'hA5), "R4 data", rd_data, 8'h11 ^ 8'hA5);
    drive_dir(1'b0, 5'd0, 7'h0C, 8'h00);
    #1;
    check(sfr_sel === 1'b1 && core_sel === 1'b0, "R4 low edge 0x0C", {sfr_sel, core_sel}, 2'b10);
    step();
    drive_dir(1'b0, 5'd9, 7'h1F, 8'h00);
    #1;
    check(sfr_sel === 1'b1 && reg_addr === 12'h49F, "R4 high edge 0x1F", reg_addr, 12'h49F);
    step();
    idle();
    check(rd_data === (8'h9F ^ 8'hA5), "R4 data bank9", rd_data, 8'h9F ^ 8'hA5);
  endtask

  task automatic t_common();
    wr_dir(5'd0, 7'h7F, 8'h5A);
    rd_dir_chk(5'd31, 7'h7F, 8'h5A, "R6 bank31 sees bank0 write");
    wr_dir(5'd20, 7'h70, 8'hC3);
    rd_dir_chk(5'd1, 7'h70, 8'hC3, "R6 bank1 sees bank20 write");
  endtask

  task automatic t_unimpl();
    drive_dir(1'b1, 5'd3, 7'h20, 8'hEE);
    #1;
    check(core_sel === 1'b0 && sfr_sel === 1'b0, "R7 no strobe", {core_sel, sfr_sel}, 0);
    step();
    idle();
    rd_dir_chk(5'd3, 7'h20, 8'h00, "R7 read zero bank3");
    rd_dir_chk(5'd31, 7'h6F, 8'h00, "R7 read zero bank31");
    rd_dir_chk(5'd0, 7'h70, 8'hC3, "R7 common unchanged");
    rd_dir_chk(5'd0, 7'h20, 8'h00, "R7 read zero after unwritten? no");
  endtask

  task automatic t_indirect();
    drive_ind(1'b1, 16'h0140, 8'h77);
    step();
    idle();
    rd_dir_chk(5'd2, 7'h40, 8'h77, "R8 indirect write visible direct");
    drive_ind(1'b0, 16'h7085, 8'h00);
    #1;
    check(core_sel === 1'b1 && reg_addr === 12'h085, "R8 high bits ignored", reg_addr, 12'h085);
    step();
    idle();
    check(rd_valid === 1'b1 && rd_data === (8'h85 ^ 8'h3C), "R8 data", rd_data, 8'h85 ^ 8'h3C);
  endtask

  task automatic t_prog_read();
    drive_ind(1'b0, 16'h8140, 8'h00);
    #1;
    check(core_sel === 1'b0 && sfr_sel === 1'b0, "R9 no strobe", {core_sel, sfr_sel}, 0);
    step();
    check(stall === 1'b1 && rd_valid === 1'b0, "R9 stall cycle", {stall, rd_valid}, 2'b10);
    drive_dir(1'b1, 5'd2, 7'h40, 8'h99);
    #1;
    check(core_sel === 1'b0 && sfr_sel === 1'b0, "R11 no strobe in stall", {core_sel, sfr_sel}, 0);
    step();
    idle();
    check(stall === 1'b0 && rd_valid === 1'b1 && pm_hit === 1'b1 && rd_data === 8'h00,
          "R9 result", {stall, rd_valid, pm_hit, rd_data}, 11'h300);
    step();
    check(rd_valid === 1'b0 && pm_hit === 1'b0, "R9 single result", {rd_valid, pm_hit}, 0);
    rd_dir_chk(5'd2, 7'h40, 8'h77, "R11 write in stall ignored");
    drive_dir(1'b0, 5'd4, 7'h05, 8'h00);
    #1;
    check(core_sel === 1'b1, "R11 stall over", core_sel, 1);
    step();
    idle();
  endtask

  task automatic t_prog_write();
    drive_ind(1'b1, 16'h8140, 8'h55);
    #1;
    check(core_sel === 1'b0 && sfr_sel === 1'b0, "R10 no strobe", {core_sel, sfr_sel}, 0);
    step();
    idle();
    check(stall === 1'b0 && rd_valid === 1'b0, "R10 no stall", {stall, rd_valid}, 0);
    rd_dir_chk(5'd2, 7'h40, 8'h77, "R10 ram unchanged");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    #1;
    t_reset();
    t_gpr_banks();
    t_core();
    t_sfr();
    t_common();
    wr_dir(5'd0, 7'h20, 8'h00);
    t_unimpl();
    t_indirect();
    t_prog_read();
    t_prog_write();
    step();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule